// File: doc/BRIEF.md
# Reset Cause Recorder

This block keeps a sticky record of why the system was last reset, and it freezes snapshots of alert and CPU crash data at the moment of a reset. Single-cycle event strobes mark each kind of reset:
- an always-on reset (power-on or scan),
- a low-power-entry reset,
- a debug reset,
- a software reset,
- a vector of hardware reset requests.

Each event sets its own bit in the cause register. The two crash-dump channels latch their snapshot inputs when their enable bit is set.

After an always-on reset, recording is held off until the CPU reports that its own reset has been released. While recording is held off, the block ignores every other reset event. Software reads the cause register and clears it with write-one-to-clear writes. Software also programs the two dump-enable bits through a simple write port.

Top module: `rst_cause_rec`

## Requirements
- R1: While `rst_ni` is low, the outputs show the always-on state: the cause is exactly 1 and recording is held off. The dump-enable bits and both latched dumps are 0.
- R2: An `aon_rst_i` strobe overwrites the cause with exactly 1. It clears both dump-enable bits and both latched dumps to zero, and it holds off recording again.
- R3: While recording is held off, non-always-on events leave the cause, the enables and the dumps unchanged. Recording resumes after the first clock edge at which `cpu_rst_released_i` is sampled high. An event in the cycle of that edge is still ignored.
- R4: A low-power-entry event ORs cause bit 1 (value 2) into the register. It keeps the dump-enable bits and latches the snapshot of each enabled channel.
- R5: A debug event ORs cause bit 2 (value 4) into the register. It keeps the dump-enable bits and latches each enabled channel.
- R6: A software event ORs cause bit 3 (value 8) into the register. It latches each enabled channel using the enables it found, and then clears both enables.
- R7: A hardware request vector is ORed into the cause at bits 4 and up, so request 0 alone gives 16. The event latches the enabled channels and then clears both enables.
- R8: A channel whose enable bit is 0 when an event arrives keeps its previously latched dump.
- R9: Cause bits are sticky and accumulate by OR. A write clears each cause bit written as 1, so writing all ones gives 0. An event in the same cycle as a write still sets its bit.
- R10: A dump-enable write loads bit 0 (alert channel) and bit 1 (CPU channel). An enable-clearing event in the same cycle overrides the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, same effect as an always-on reset |
| aon_rst_i | input | 1 | Always-on (power-on or scan) reset event strobe |
| lowpwr_rst_i | input | 1 | Low-power-entry reset event strobe |
| dbg_rst_i | input | 1 | Debug reset event strobe |
| sw_rst_i | input | 1 | Software reset event strobe |
| hw_rst_req_i | input | HW_REQS | Hardware reset request strobes |
| cpu_rst_released_i | input | 1 | High once the CPU reset is inactive |
| cause_we_i | input | 1 | Cause register write strobe |
| cause_wdata_i | input | 4+HW_REQS | Write-one-to-clear mask for the cause |
| dump_en_we_i | input | 1 | Dump-enable write strobe |
| dump_en_wdata_i | input | 2 | New enables: bit 0 alert, bit 1 CPU |
| alert_snap_i | input | ALERT_W | Live alert crash data |
| cpu_snap_i | input | CPU_W | Live CPU crash data |
| cause_o | output | 4+HW_REQS | Recorded reset cause |
| dump_en_o | output | 2 | Dump-enable bits |
| alert_dump_o | output | ALERT_W | Latched alert dump |
| cpu_dump_o | output | CPU_W | Latched CPU dump |

## Verification
Every result is held in a register, so each one appears on the outputs exactly one clock edge after the cycle in which its strobe or write was presented. This applies to the cause, the enables, the dumps and the hold-off flag. The bench drives inputs on falling edges, removes them on the next falling edge, and samples at that same falling edge. Each check therefore sees the state produced by exactly one rising edge. The release edge for the hold-off is tested by presenting an event in the same cycle as the first high sample of `cpu_rst_released_i`, and expecting that event to have no effect.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
   // Cause register bit positions; software decodes these.
   localparam int CauseAonBit   = 0;
   localparam int CauseLpBit    = 1;
   localparam int CauseDbgBit   = 2;
   localparam int CauseSwBit    = 3;
   localparam int CauseHwBase   = 4;

   // Dump-enable bit positions.
   typedef enum logic [0:0] {
      ChAlert = 1'b0,
      ChCpu   = 1'b1
   } dump_ch_e;
   localparam int NumDumpCh = 2;
endpackage

// File: rtl/rcr_gate.sv
module rcr_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic aon_i,
   input  logic released_i,
   output logic blocked_o
);
   logic blocked_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         blocked_q <= 1'b1;
      else if (aon_i)      blocked_q <= 1'b1;
      else if (released_i) blocked_q <= 1'b0;
   end

   assign blocked_o = blocked_q;
endmodule

// File: rtl/rcr_cause.sv
module rcr_cause #(
   parameter  int HW_REQS = 4,
   localparam int CAUSE_W = rcr_pkg::CauseHwBase + HW_REQS
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               aon_i,
   input  logic               allow_i,
   input  logic               lp_i,
   input  logic               dbg_i,
   input  logic               sw_i,
   input  logic [HW_REQS-1:0] hw_i,
   input  logic               we_i,
   input  logic [CAUSE_W-1:0] wdata_i,
   output logic [CAUSE_W-1:0] cause_o
);
   logic [CAUSE_W-1:0] ev;
   logic [CAUSE_W-1:0] q;

   // Bit 0 is only ever set by the always-on path.
   assign ev = {hw_i, sw_i, dbg_i, lp_i, 1'b0};

   for (genvar b = 0; b < CAUSE_W; b++) begin : g_bit
      localparam logic RstVal = (b == rcr_pkg::CauseAonBit);
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    q[b] <= RstVal;
         else if (aon_i) q[b] <= RstVal;
         else            q[b] <= (q[b] & ~(we_i & wdata_i[b])) | (allow_i & ev[b]);
      end
   end

   assign cause_o = q;
endmodule

// File: rtl/rcr_dump.sv
module rcr_dump #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         aon_i,
   input  logic         take_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '0;
      else if (aon_i)  q <= '0;
      else if (take_i) q <= data_i;
   end

   assign q_o = q;
endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec #(
   parameter  int HW_REQS = 4,
   parameter  int ALERT_W = 16,
   parameter  int CPU_W   = 32,
   localparam int CAUSE_W = rcr_pkg::CauseHwBase + HW_REQS
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               aon_rst_i,
   input  logic               lowpwr_rst_i,
   input  logic               dbg_rst_i,
   input  logic               sw_rst_i,
   input  logic [HW_REQS-1:0] hw_rst_req_i,
   input  logic               cpu_rst_released_i,
   input  logic               cause_we_i,
   input  logic [CAUSE_W-1:0] cause_wdata_i,
   input  logic               dump_en_we_i,
   input  logic [1:0]         dump_en_wdata_i,
   input  logic [ALERT_W-1:0] alert_snap_i,
   input  logic [CPU_W-1:0]   cpu_snap_i,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [1:0]         dump_en_o,
   output logic [ALERT_W-1:0] alert_dump_o,
   output logic [CPU_W-1:0]   cpu_dump_o
);
   import rcr_pkg::*;

   if (HW_REQS < 1 || HW_REQS > 27) begin : g_bad_hw
      $error("HW_REQS out of range");
   end
   if (ALERT_W < 1 || CPU_W < 1) begin : g_bad_w
      $error("dump widths must be positive");
   end

   logic                 capture_blocked;
   logic                 allow;
   logic                 any_ev;
   logic                 drop_en_ev;
   logic [NumDumpCh-1:0] en_q;
   logic [NumDumpCh-1:0] take;

   rcr_gate u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .aon_i      (aon_rst_i),
      .released_i (cpu_rst_released_i),
      .blocked_o  (capture_blocked)
   );

   assign allow      = ~capture_blocked;
   assign any_ev     = lowpwr_rst_i | dbg_rst_i | sw_rst_i | (|hw_rst_req_i);
   assign drop_en_ev = allow & (sw_rst_i | (|hw_rst_req_i));

   rcr_cause #(.HW_REQS(HW_REQS)) u_cause (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .aon_i   (aon_rst_i),
      .allow_i (allow),
      .lp_i    (lowpwr_rst_i),
      .dbg_i   (dbg_rst_i),
      .sw_i    (sw_rst_i),
      .hw_i    (hw_rst_req_i),
      .we_i    (cause_we_i),
      .wdata_i (cause_wdata_i),
      .cause_o (cause_o)
   );

   // Enables: always-on clears, sw/hw events clear, else software write loads.
   for (genvar c = 0; c < NumDumpCh; c++) begin : g_en
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)           en_q[c] <= 1'b0;
         else if (aon_rst_i)    en_q[c] <= 1'b0;
         else if (drop_en_ev)   en_q[c] <= 1'b0;
         else if (dump_en_we_i) en_q[c] <= dump_en_wdata_i[c];
      end
      assign take[c] = allow & any_ev & en_q[c];
   end

   rcr_dump #(.W(ALERT_W)) u_alert_dump (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .aon_i  (aon_rst_i),
      .take_i (take[ChAlert]),
      .data_i (alert_snap_i),
      .q_o    (alert_dump_o)
   );

   rcr_dump #(.W(CPU_W)) u_cpu_dump (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .aon_i  (aon_rst_i),
      .take_i (take[ChCpu]),
      .data_i (cpu_snap_i),
      .q_o    (cpu_dump_o)
   );

   assign dump_en_o = en_q;
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker #(
   parameter  int HW_REQS = 4,
   parameter  int ALERT_W = 16,
   parameter  int CPU_W   = 32,
   localparam int CAUSE_W = 4 + HW_REQS
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               aon_rst_i,
   input logic               lowpwr_rst_i,
   input logic               dbg_rst_i,
   input logic               sw_rst_i,
   input logic [HW_REQS-1:0] hw_rst_req_i,
   input logic               cause_we_i,
   input logic [CAUSE_W-1:0] cause_wdata_i,
   input logic               dump_en_we_i,
   input logic [CAUSE_W-1:0] cause_o,
   input logic [1:0]         dump_en_o,
   input logic [ALERT_W-1:0] alert_dump_o,
   input logic [CPU_W-1:0]   cpu_dump_o,
   input logic               blocked_i
);
   logic quiet_sw;
   assign quiet_sw = !cause_we_i && !dump_en_we_i && !aon_rst_i;

   assert_aon_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      aon_rst_i |=> cause_o == CAUSE_W'(1) && dump_en_o == 2'b00 &&
                    alert_dump_o == '0 && cpu_dump_o == '0);

   assert_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blocked_i && quiet_sw |=> $stable(cause_o) && $stable(dump_en_o) &&
                               $stable(alert_dump_o) && $stable(cpu_dump_o));

   assert_lowpwr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !blocked_i && lowpwr_rst_i && quiet_sw && !sw_rst_i && hw_rst_req_i == '0
      |=> cause_o[1] && $stable(dump_en_o));

   assert_dbg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !blocked_i && dbg_rst_i && quiet_sw && !sw_rst_i && hw_rst_req_i == '0
      |=> cause_o[2] && $stable(dump_en_o));

   assert_sw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !blocked_i && sw_rst_i && !aon_rst_i |=> cause_o[3] && dump_en_o == 2'b00);

   assert_hw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !blocked_i && hw_rst_req_i != '0 && !aon_rst_i
      |=> (cause_o[CAUSE_W-1:4] & $past(hw_rst_req_i)) == $past(hw_rst_req_i) &&
          dump_en_o == 2'b00);

   assert_keep_alert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !aon_rst_i && !dump_en_o[0] |=> $stable(alert_dump_o));

   assert_keep_cpu_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !aon_rst_i && !dump_en_o[1] |=> $stable(cpu_dump_o));

   assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cause_we_i && cause_wdata_i == '1 && !aon_rst_i && !lowpwr_rst_i && !dbg_rst_i &&
      !sw_rst_i && hw_rst_req_i == '0 |=> cause_o == '0);
endmodule

bind rst_cause_rec rcr_checker #(
   .HW_REQS (HW_REQS),
   .ALERT_W (ALERT_W),
   .CPU_W   (CPU_W)
) u_rcr_checker (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .aon_rst_i     (aon_rst_i),
   .lowpwr_rst_i  (lowpwr_rst_i),
   .dbg_rst_i     (dbg_rst_i),
   .sw_rst_i      (sw_rst_i),
   .hw_rst_req_i  (hw_rst_req_i),
   .cause_we_i    (cause_we_i),
   .cause_wdata_i (cause_wdata_i),
   .dump_en_we_i  (dump_en_we_i),
   .cause_o       (cause_o),
   .dump_en_o     (dump_en_o),
   .alert_dump_o  (alert_dump_o),
   .cpu_dump_o    (cpu_dump_o),
   .blocked_i     (capture_blocked)
);

// File: tb/rst_cause_rec_bench.sv
`timescale 1ns/1ps
module rst_cause_rec_bench;
   localparam int HW = 4;
   localparam int CW = 8;
   localparam int AW = 16;
   localparam int PW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          aon = 0, lp = 0, dbg = 0, sw = 0;
   logic [HW-1:0] hw = '0;
   logic          rel = 0;
   logic          c_we = 0;
   logic [CW-1:0] c_wd = '0;
   logic          e_we = 0;
   logic [1:0]    e_wd = '0;
   logic [AW-1:0] a_snap = '0;
   logic [PW-1:0] p_snap = '0;
   logic [CW-1:0] cause;
   logic [1:0]    en;
   logic [AW-1:0] a_dump;
   logic [PW-1:0] p_dump;

   always #2 clk = ~clk;

   rst_cause_rec u_rst_cause_rec (
      .clk_i(clk), .rst_ni(rst_n), .aon_rst_i(aon), .lowpwr_rst_i(lp),
      .dbg_rst_i(dbg), .sw_rst_i(sw), .hw_rst_req_i(hw), .cpu_rst_released_i(rel),
      .cause_we_i(c_we), .cause_wdata_i(c_wd), .dump_en_we_i(e_we),
      .dump_en_wdata_i(e_wd), .alert_snap_i(a_snap), .cpu_snap_i(p_snap),
      .cause_o(cause), .dump_en_o(en), .alert_dump_o(a_dump), .cpu_dump_o(p_dump)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // One cycle: inputs set before this call are seen by one rising edge.
   task automatic cyc();
      @(negedge clk);
      aon = 0; lp = 0; dbg = 0; sw = 0; hw = '0;
      c_we = 0; c_wd = '0; e_we = 0; e_wd = '0;
   endtask

   // kind: 1 low-power, 2 debug, 3 software, 4 hardware
   typedef struct packed {
      logic [2:0] kind;
      logic [3:0] hwv;
      logic [1:0] en_in;
      logic [7:0] cause_exp;
      logic [1:0] en_exp;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{3'd1, 4'h0, 2'b11, 8'h02, 2'b11},
      '{3'd2, 4'h0, 2'b01, 8'h04, 2'b01},
      '{3'd3, 4'h0, 2'b10, 8'h08, 2'b00},
      '{3'd4, 4'h1, 2'b11, 8'h10, 2'b00},
      '{3'd4, 4'hA, 2'b00, 8'hA0, 2'b00},
      '{3'd1, 4'h0, 2'b00, 8'h02, 2'b00}
   };

   initial begin
      #(100000 * 4);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [AW-1:0] exp_a;
      logic [PW-1:0] exp_p;
      string tag;
      exp_a = '0;
      exp_p = '0;
      repeat (3) @(negedge clk);
      check("R1 cause", cause, 1);
      check("R1 en", en, 0);
      check("R1 alert", a_dump, 0);
      check("R1 cpu", p_dump, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 enable load, R3 hold-off
      e_we = 1; e_wd = 2'b11; cyc();
      check("R10 en load", en, 3);
      a_snap = 16'h1111; p_snap = 32'h2222_2222;
      lp = 1; cyc();
      check("R3 blocked cause", cause, 1);
      check("R3 blocked alert", a_dump, 0);
      check("R3 blocked en", en, 3);
      rel = 1; dbg = 1; cyc();
      check("R3 release edge ignored", cause, 1);

      for (int i = 0; i < 6; i++) begin
         c_we = 1; c_wd = '1; e_we = 1; e_wd = VECS[i].en_in; cyc();
         a_snap = AW'(16'hA000 + i);
         p_snap = PW'(32'hC0DE_0000 + i);
         case (VECS[i].kind)
            3'd1:    begin lp  = 1; tag = "R4"; end
            3'd2:    begin dbg = 1; tag = "R5"; end
            3'd3:    begin sw  = 1; tag = "R6"; end
            default: begin hw  = VECS[i].hwv; tag = "R7"; end
         endcase
         if (VECS[i].en_in[0]) exp_a = a_snap;
         if (VECS[i].en_in[1]) exp_p = p_snap;
         cyc();
         check({tag, " cause"}, cause, VECS[i].cause_exp);
         check({tag, " en"}, en, VECS[i].en_exp);
         check("R8 alert dump", a_dump, exp_a);
         check("R8 cpu dump", p_dump, exp_p);
      end

      // R9 sticky OR and partial clear
      c_we = 1; c_wd = '1; cyc();
      lp = 1; cyc();
      dbg = 1; cyc();
      check("R9 sticky", cause, 6);
      c_we = 1; c_wd = 8'h02; cyc();
      check("R9 partial clear", cause, 4);

      // R9/R10 same-cycle write and event
      e_we = 1; e_wd = 2'b11; cyc();
      a_snap = 16'h5A5A;
      c_we = 1; c_wd = '1; e_we = 1; e_wd = 2'b11; sw = 1; cyc();
      check("R9 event wins write", cause, 8);
      check("R10 clear beats write", en, 0);
      check("R6 latch", a_dump, 16'h5A5A);

      // R2 always-on reset, then R3 re-armed hold-off
      e_we = 1; e_wd = 2'b11; cyc();
      aon = 1; rel = 0; cyc();
      check("R2 cause", cause, 1);
      check("R2 en", en, 0);
      check("R2 alert", a_dump, 0);
      check("R2 cpu", p_dump, 0);
      e_we = 1; e_wd = 2'b11; cyc();
      a_snap = 16'h7777;
      lp = 1; cyc();
      check("R3 re-armed cause", cause, 1);
      check("R3 re-armed alert", a_dump, 0);
      rel = 1; cyc();
      lp = 1; cyc();
      check("R4 after release cause", cause, 3);
      check("R4 after release alert", a_dump, 16'h7777);
      finish_run();
   end
endmodule